// File: doc/BRIEF.md
# Intel HEX Record Loader

This block sits behind a serial receiver and turns a stream of ASCII characters into writes on a RAM port. It waits for a colon, then reads a record made of two-digit hex fields: a byte count, a 16-bit load address (high byte first), a record type, the payload bytes and a checksum byte. For data records it writes each payload byte to RAM at the load address, then steps the address by one for each byte. Every character that arrives is sent back unchanged on an echo channel, so a terminal on the far side sees what it sent.

Each record's checksum is checked. A failure sets a sticky error flag and parsing goes on with the next record, so the whole image is still loaded. An end-of-file record stops parsing and raises a done flag, and the error flag is valid at the same time. Extended-address records (type 4) and other non-data types are read and included in the checksum, but their payload is thrown away. A start pulse clears both flags and begins a new load.

Top module: `hexld_top`

## Requirements
- R1: Every cycle with `rx_valid_i` high produces, one clock later, a one-cycle `echo_valid_o` pulse with `echo_data_o` equal to the received byte. This holds in every state, including while hunting and after done.
- R2: While hunting for a record, every character other than ':' (0x3A) is ignored. No write happens and the error flag does not change.
- R3: Inside a record, the fields are read in this order: count, address high, address low, type, payload, checksum. Each field is two hex digits, high nibble first. Accepted digits are 0-9, A-F and, when `ACCEPT_LOWER` is 1 (the default), a-f.
- R4: For a type 0x00 record, each payload byte produces one `wr_en_o` pulse of one cycle, one clock after its second digit. The address starts at the record address and rises by one for each byte, wrapping modulo 2^ADDR_W.
- R5: A record of any type other than 0x00 or 0x01 (for example 0x04) writes nothing. Its payload bytes still count toward the checksum.
- R6: A record is good when the sum modulo 256 of count, both address bytes, type, all payload bytes and the checksum byte is zero. Otherwise `error_o` rises one clock after the last checksum digit and stays high. The following records are still parsed and written.
- R7: A character that is not a hex digit inside a record (including ':') sets `error_o` and returns the parser to hunting. The rest of that record is ignored.
- R8: A type 0x01 record raises `done_o` one clock after its last checksum digit, with `error_o` valid in the same cycle. After that, characters are echoed but not parsed, and nothing is written.
- R9: After reset, `done_o`, `error_o`, `wr_en_o` and `echo_valid_o` are low. A `start_i` pulse clears `done_o` and `error_o` on the next clock and returns the parser to hunting.
- R10: A data record with count 0 reads its checksum right after the type field and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new load: clear flags, hunt for ':' |
| rx_valid_i | input | 1 | Received character valid |
| rx_data_i | input | 8 | Received character |
| echo_valid_o | output | 1 | Echo character valid (one cycle) |
| echo_data_o | output | 8 | Echoed character |
| wr_en_o | output | 1 | RAM write strobe (one cycle per byte) |
| wr_addr_o | output | ADDR_W | RAM write address |
| wr_data_o | output | 8 | RAM write data |
| done_o | output | 1 | End-of-file record seen |
| error_o | output | 1 | Sticky checksum or character error |

## Verification
On every cycle, the assertions check the following. The echo follows each received character one clock later. Write strobes never last longer than one cycle. The error and done flags stay set until a start pulse, and a start clears both. Nothing is written once done is high. Only the bench scenarios can show the rest. Payload bytes must reach the correct addresses, including wrap at the top of the address space. Checksums must be judged correctly for data, extended-address and empty records. A bad digit must drop the rest of its record, and a failed record must not stop later records from loading.

// File: rtl/hexld_pkg.sv
package hexld_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] CH_MARK  = 8'h3A;
   localparam logic [BYTE_W-1:0] TYP_DATA = 8'h00;
   localparam logic [BYTE_W-1:0] TYP_EOF  = 8'h01;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_REC,
      ST_FIN
   } ld_state_e;

   typedef enum logic [2:0] {
      FLD_CNT,
      FLD_AHI,
      FLD_ALO,
      FLD_TYP,
      FLD_PAY,
      FLD_SUM
   } ld_field_e;
endpackage

// File: rtl/hexld_digit.sv
module hexld_digit #(
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic [7:0] ch_i,
   output logic       is_hex_o,
   output logic [3:0] nib_o
);
   logic       dec_hit;
   logic       up_hit;
   logic       lo_hit;
   logic [7:0] dec_off;
   logic [7:0] up_off;
   logic [7:0] lo_off;

   assign dec_off = ch_i - 8'h30;
   assign up_off  = ch_i - 8'h37;
   assign lo_off  = ch_i - 8'h57;
   assign dec_hit = (ch_i >= 8'h30) && (ch_i <= 8'h39);
   assign up_hit  = (ch_i >= 8'h41) && (ch_i <= 8'h46);

   generate
      if (ACCEPT_LOWER) begin : g_lower
         assign lo_hit = (ch_i >= 8'h61) && (ch_i <= 8'h66);
      end else begin : g_upper_only
         assign lo_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      nib_o = 4'h0;
      if (dec_hit)     nib_o = dec_off[3:0];
      else if (up_hit) nib_o = up_off[3:0];
      else if (lo_hit) nib_o = lo_off[3:0];
   end

   assign is_hex_o = dec_hit | up_hit | lo_hit;
endmodule

// File: rtl/hexld_pair.sv
module hexld_pair #(
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       en_i,
   input  logic [7:0] ch_i,
   output logic       byte_valid_o,
   output logic [7:0] byte_o,
   output logic       bad_o
);
   logic       is_hex;
   logic [3:0] nib;
   logic       phase_q;
   logic [3:0] hi_q;

   hexld_digit #(.ACCEPT_LOWER(ACCEPT_LOWER)) u_digit (
      .ch_i     (ch_i),
      .is_hex_o (is_hex),
      .nib_o    (nib)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         hi_q    <= 4'h0;
      end else if (clr_i) begin
         phase_q <= 1'b0;
      end else if (en_i) begin
         if (!is_hex) begin
            phase_q <= 1'b0;
         end else begin
            if (!phase_q) hi_q <= nib;
            phase_q <= ~phase_q;
         end
      end
   end

   assign byte_valid_o = en_i & is_hex & phase_q & ~clr_i;
   assign byte_o       = {hi_q, nib};
   assign bad_o        = en_i & ~is_hex & ~clr_i;
endmodule

// File: rtl/hexld_record.sv
module hexld_record
   import hexld_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ch_valid_i,
   input  logic [7:0]        ch_i,
   input  logic              byte_valid_i,
   input  logic [7:0]        byte_i,
   input  logic              bad_i,
   output logic              busy_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              done_o,
   output logic              error_o
);
   ld_state_e        state_q;
   ld_field_e        field_q;
   logic [7:0]       cnt_q;
   logic [7:0]       typ_q;
   logic [15:0]      addr_q;
   logic [7:0]       sum_q;
   logic [7:0]       sum_nx;
   logic             err_q;
   logic             done_q;
   logic             wr_q;
   logic [ADDR_W-1:0] wa_q;
   logic [7:0]       wd_q;

   assign sum_nx = sum_q + byte_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         field_q <= FLD_CNT;
         cnt_q   <= 8'h00;
         typ_q   <= 8'h00;
         addr_q  <= 16'h0000;
         sum_q   <= 8'h00;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         wr_q    <= 1'b0;
         wa_q    <= '0;
         wd_q    <= 8'h00;
      end else begin
         wr_q <= 1'b0;
         if (start_i) begin
            state_q <= ST_HUNT;
            field_q <= FLD_CNT;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_HUNT: begin
                  if (ch_valid_i && ch_i == CH_MARK) begin
                     state_q <= ST_REC;
                     field_q <= FLD_CNT;
                  end
               end
               ST_REC: begin
                  if (bad_i) begin
                     err_q   <= 1'b1;
                     state_q <= ST_HUNT;
                  end else if (byte_valid_i) begin
                     unique case (field_q)
                        FLD_CNT: begin
                           cnt_q   <= byte_i;
                           sum_q   <= byte_i;
                           field_q <= FLD_AHI;
                        end
                        FLD_AHI: begin
                           addr_q[15:8] <= byte_i;
                           sum_q        <= sum_nx;
                           field_q      <= FLD_ALO;
                        end
                        FLD_ALO: begin
                           addr_q[7:0] <= byte_i;
                           sum_q       <= sum_nx;
                           field_q     <= FLD_TYP;
                        end
                        FLD_TYP: begin
                           typ_q   <= byte_i;
                           sum_q   <= sum_nx;
                           field_q <= (cnt_q == 8'h00) ? FLD_SUM : FLD_PAY;
                        end
                        FLD_PAY: begin
                           sum_q <= sum_nx;
                           cnt_q <= cnt_q - 8'd1;
                           if (typ_q == TYP_DATA) begin
                              wr_q <= 1'b1;
                              wa_q <= addr_q[ADDR_W-1:0];
                              wd_q <= byte_i;
                           end
                           addr_q <= addr_q + 16'd1;
                           if (cnt_q == 8'd1) field_q <= FLD_SUM;
                        end
                        FLD_SUM: begin
                           if (sum_nx != 8'h00) err_q <= 1'b1;
                           field_q <= FLD_CNT;
                           if (typ_q == TYP_EOF) begin
                              state_q <= ST_FIN;
                              done_q  <= 1'b1;
                           end else begin
                              state_q <= ST_HUNT;
                           end
                        end
                        default: field_q <= FLD_CNT;
                     endcase
                  end
               end
               ST_FIN: state_q <= ST_FIN;
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign busy_o    = (state_q == ST_REC);
   assign wr_en_o   = wr_q;
   assign wr_addr_o = wa_q;
   assign wr_data_o = wd_q;
   assign done_o    = done_q;
   assign error_o   = err_q;

   p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q);
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !start_i) |=> err_q);
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start_i) |=> done_q);
   p_no_wr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !wr_q);
   p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_q && !err_q && !wr_q));
endmodule

// File: rtl/hexld_top.sv
module hexld_top #(
   parameter int unsigned ADDR_W       = 16,
   parameter bit          ACCEPT_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_data_i,
   output logic              echo_valid_o,
   output logic [7:0]        echo_data_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              done_o,
   output logic              error_o
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("hexld_top: ADDR_W must lie in 1..16");
      end
   endgenerate

   logic       busy;
   logic       byte_valid;
   logic [7:0] byte_val;
   logic       bad;
   logic       echo_v_q;
   logic [7:0] echo_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         echo_v_q <= 1'b0;
         echo_d_q <= 8'h00;
      end else begin
         echo_v_q <= rx_valid_i;
         if (rx_valid_i) echo_d_q <= rx_data_i;
      end
   end

   assign echo_valid_o = echo_v_q;
   assign echo_data_o  = echo_d_q;

   hexld_pair #(.ACCEPT_LOWER(ACCEPT_LOWER)) u_pair (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (start_i),
      .en_i         (rx_valid_i & busy),
      .ch_i         (rx_data_i),
      .byte_valid_o (byte_valid),
      .byte_o       (byte_val),
      .bad_o        (bad)
   );

   hexld_record #(.ADDR_W(ADDR_W)) u_rec (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .ch_valid_i   (rx_valid_i),
      .ch_i         (rx_data_i),
      .byte_valid_i (byte_valid),
      .byte_i       (byte_val),
      .bad_i        (bad),
      .busy_o       (busy),
      .wr_en_o      (wr_en_o),
      .wr_addr_o    (wr_addr_o),
      .wr_data_o    (wr_data_o),
      .done_o       (done_o),
      .error_o      (error_o)
   );

   p_echo_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i |=> (echo_valid_o && echo_data_o == $past(rx_data_i)));
   p_echo_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_i |=> !echo_valid_o);
endmodule

// File: tb/hexld_top_tb.sv
module hexld_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              rx_valid_i = 1'b0;
   logic [7:0]        rx_data_i = 8'h00;
   logic              echo_valid_o;
   logic [7:0]        echo_data_o;
   logic              wr_en_o;
   logic [ADDR_W-1:0] wr_addr_o;
   logic [7:0]        wr_data_o;
   logic              done_o;
   logic              error_o;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          mon_on = 1'b0;
   logic [7:0]  echo_q[$];
   logic [23:0] wr_q[$];
   logic [7:0]  pay [0:31];

   always #(CLK_PERIOD/2) clk = ~clk;

   hexld_top #(.ADDR_W(ADDR_W), .ACCEPT_LOWER(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
      .echo_valid_o(echo_valid_o), .echo_data_o(echo_data_o),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .done_o(done_o), .error_o(error_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (echo_valid_o) begin
            if (echo_q.size() == 0) check("R1", "echo without char", 1, 0);
            else check("R1", "echo data", {24'h0, echo_data_o}, {24'h0, echo_q.pop_front()});
         end
         if (wr_en_o) begin
            if (wr_q.size() == 0)
               check("R4", "unexpected write", {8'h0, wr_addr_o, wr_data_o}, 32'hFFFFFFFF);
            else
               check("R4", "write addr/data", {8'h0, wr_addr_o, wr_data_o}, {8'h0, wr_q.pop_front()});
         end
      end
   end

   function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      return (lower ? 8'h57 : 8'h37) + {4'h0, n};
   endfunction

   task automatic send_char(input logic [7:0] c);
      echo_q.push_back(c);
      rx_valid_i = 1'b1;
      rx_data_i  = c;
      @(negedge clk);
      rx_valid_i = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit lower);
      send_char(hexc(b[7:4], lower));
      send_char(hexc(b[3:0], lower));
   endtask

   task automatic send_record(input logic [7:0] typ, input logic [15:0] addr,
                              input int len, input bit corrupt,
                              input bit expect_wr, input bit lower);
      logic [7:0] s;
      s = len[7:0] + addr[15:8] + addr[7:0] + typ;
      for (int i = 0; i < len; i++) s = s + pay[i];
      s = 8'h00 - s;
      if (corrupt) s = s ^ 8'h01;
      if (expect_wr && typ == 8'h00)
         for (int i = 0; i < len; i++) wr_q.push_back({addr + i[15:0], pay[i]});
      send_char(8'h3A);
      send_byte(len[7:0], lower);
      send_byte(addr[15:8], lower);
      send_byte(addr[7:0], lower);
      send_byte(typ, lower);
      for (int i = 0; i < len; i++) send_byte(pay[i], lower);
      send_char(hexc(s[7:4], lower));
      send_char(hexc(s[3:0], lower));
   endtask

   task automatic crlf();
      send_char(8'h0D);
      send_char(8'h0A);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic finish_run();
      check("R4", "pending writes left", wr_q.size(), 0);
      check("R1", "pending echoes left", echo_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      check("R9", "reset done", done_o, 0);
      check("R9", "reset error", error_o, 0);
      check("R9", "reset wr_en", wr_en_o, 0);
      check("R9", "reset echo", echo_valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R2: garbage while hunting
      send_char("x"); send_char("1"); send_char("F"); crlf();
      check("R2", "hunt garbage no error", error_o, 0);

      // R3 R4: directed data record, uppercase
      pay[0] = 8'hDE; pay[1] = 8'hAD; pay[2] = 8'h5A;
      send_record(8'h00, 16'h1234, 3, 1'b0, 1'b1, 1'b0); crlf();
      check("R6", "good record no error", error_o, 0);

      // R3 R4: lowercase digits and address wrap
      pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3; pay[3] = 8'hF4;
      send_record(8'h00, 16'hFFFE, 4, 1'b0, 1'b1, 1'b1); crlf();
      check("R4", "wrap record no error", error_o, 0);

      // R5: extended address record writes nothing
      pay[0] = 8'h12; pay[1] = 8'h34;
      send_record(8'h04, 16'h0000, 2, 1'b0, 1'b0, 1'b0); crlf();
      check("R5", "type 4 sum good", error_o, 0);

      // R10: empty data record
      send_record(8'h00, 16'h4000, 0, 1'b0, 1'b1, 1'b0); crlf();
      check("R10", "empty record no error", error_o, 0);

      // R6: random good records
      for (int r = 0; r < 30; r++) begin
         int len;
         len = $urandom_range(0, 16);
         for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
         send_record(8'h00, 16'($urandom), len, 1'b0, 1'b1, r[0]);
         if (r % 3 == 0) crlf();
      end
      check("R6", "random records no error", error_o, 0);

      // R6: bad checksum sets sticky error, parsing continues
      pay[0] = 8'h77;
      send_record(8'h00, 16'h0100, 1, 1'b1, 1'b1, 1'b0);
      check("R6", "bad checksum flags error", error_o, 1);
      pay[0] = 8'h55; pay[1] = 8'h66;
      send_record(8'h00, 16'h0200, 2, 1'b0, 1'b1, 1'b0);
      check("R6", "error sticky after good record", error_o, 1);

      // R9: start clears
      pulse_start();
      check("R9", "start clears error", error_o, 0);

      // R7: bad character inside a record
      send_char(8'h3A); send_char("1"); send_char("0"); send_char("G");
      check("R7", "bad char sets error", error_o, 1);
      send_char("0"); send_char("0"); send_char("1"); send_char("2");
      send_char("0"); send_char("0"); send_char("A"); send_char("B"); crlf();
      pulse_start();
      send_char(8'h3A); send_char("0"); send_char(8'h3A);
      check("R7", "colon inside record is bad", error_o, 1);
      pulse_start();
      pay[0] = 8'h99;
      send_record(8'h00, 16'h0300, 1, 1'b0, 1'b1, 1'b1);
      check("R7", "recovers after bad char", error_o, 0);

      // R8: end of file with clean load
      check("R8", "done low before eof", done_o, 0);
      send_record(8'h01, 16'h0000, 0, 1'b0, 1'b0, 1'b0);
      check("R8", "done after eof", done_o, 1);
      check("R8", "error clear with done", error_o, 0);
      pay[0] = 8'h11;
      send_record(8'h00, 16'h0500, 1, 1'b0, 1'b0, 1'b0); crlf();
      check("R8", "done holds, no parse", done_o, 1);

      // R8 R6: error reported with done
      pulse_start();
      check("R9", "start clears done", done_o, 0);
      pay[0] = 8'h22;
      send_record(8'h00, 16'h0600, 1, 1'b1, 1'b1, 1'b0);
      send_record(8'h01, 16'h0000, 0, 1'b0, 1'b0, 1'b1);
      check("R8", "done with error", done_o, 1);
      check("R8", "error reported with done", error_o, 1);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule